// File: doc/BRIEF.md
# Power Button and Lid Wake Request Logic

This block sits in front of a power state sequencer and turns two already-debounced switch levels, the power button and the lid-open sensor, into two kinds of request: power the platform on, or force it off. It watches an "any off state" level from the sequencer to decide whether a press or a lid opening should wake the platform. It also takes a one-cycle strobe that marks the sequencer's move from the running state into suspend.

A press arms two independent hold timers, counted in millisecond ticks. The short one, which is armed only when the platform is off at the moment of the press, asks for power-on. The long one, which is armed on every press, asks for a forced shutdown. Releasing the button drops both timers. A press that begins while the platform is off and is then held through both limits therefore powers the platform on and later forces it off again. Opening the lid while the platform is off asks for power-on at once. If the button is still held when the sequencer drops into suspend, the shutdown request goes out immediately and the long timer is abandoned. The sequencer treats each power-on request as also clearing any forced-shutdown condition it holds.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both request outputs are low. A button or lid level that is already high when reset is released is not treated as an edge and issues no request.
- R2: A button press (a 0 to 1 change of `btn_pressed`) while `sys_off` is 1 starts the short timer. The timer counts only the cycles in which `tick_ms` is 1, beginning after the press cycle. On the ON_HOLD_MS-th tick with the button still held, `pwr_on_req` goes to 1 in the next cycle.
- R3: A press that begins while `sys_off` is 0 never produces `pwr_on_req`, however long the button is held.
- R4: Every press starts the long timer. On the OFF_HOLD_MS-th counted tick with the button still held, `force_off_req` goes to 1 in the next cycle.
- R5: Releasing the button cancels both timers. A later press counts again from zero.
- R6: A 0 to 1 change of `lid_open` while `sys_off` is 1 raises `pwr_on_req` in the next cycle. A lid opening while `sys_off` is 0, or a lid that stays open, raises nothing.
- R7: A cycle in which `s0_to_s3` is 1 while the button is held raises `force_off_req` in the next cycle and cancels the long timer, so that hold produces no second shutdown request.
- R8: `s0_to_s3` while the button is released raises no request.
- R9: Each request is high for exactly one cycle. A timer that has fired does not fire again until the next press, and no request is raised without a cause listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| btn_pressed | input | 1 | Debounced power button, 1 = held |
| lid_open | input | 1 | Debounced lid sensor, 1 = open |
| sys_off | input | 1 | 1 while the sequencer is in any off state |
| s0_to_s3 | input | 1 | One-cycle strobe on entry to suspend from running |
| pwr_on_req | output | 1 | One-cycle power-on request |
| force_off_req | output | 1 | One-cycle forced-shutdown request |

## Verification
A counter that slips shows up as a request that arrives one or more ticks early or late, so every expected request is tied to the exact cycle in which it must appear. An arm flag that is left set when it should have been cleared shows up later, as an extra request on a subsequent tick, sometimes thousands of ticks after the stimulus that caused it. For that reason each scenario runs past both limits and then confirms that nothing further was issued. A stale edge register shows up within one cycle, either as a request right after reset or as a repeated lid wake.

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int ON_HOLD_MS  = 10,
  parameter int OFF_HOLD_MS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic btn_pressed,
  input  logic lid_open,
  input  logic sys_off,
  input  logic s0_to_s3,
  output logic pwr_on_req,
  output logic force_off_req
);
  localparam int ON_W  = $clog2(ON_HOLD_MS + 1);
  localparam int OFF_W = $clog2(OFF_HOLD_MS + 1);

  logic             primed, btn_q, lid_q;
  logic             on_arm, off_arm;
  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;

  wire press    = primed & btn_pressed & ~btn_q;
  wire lid_wake = primed & lid_open & ~lid_q & sys_off;
  wire sus_hit  = s0_to_s3 & btn_pressed;
  wire on_done  = on_arm & btn_pressed & tick_ms &
                  (on_cnt == ON_W'(ON_HOLD_MS - 1));
  wire off_done = off_arm & btn_pressed & tick_ms &
                  (off_cnt == OFF_W'(OFF_HOLD_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed        <= 1'b0;
      btn_q         <= 1'b0;
      lid_q         <= 1'b0;
      pwr_on_req    <= 1'b0;
      force_off_req <= 1'b0;
    end else begin
      primed        <= 1'b1;
      btn_q         <= btn_pressed;
      lid_q         <= lid_open;
      pwr_on_req    <= lid_wake | on_done;
      force_off_req <= sus_hit | off_done;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_arm <= 1'b0;
      on_cnt <= '0;
    end else if (!btn_pressed) begin
      on_arm <= 1'b0;
    end else if (press) begin
      on_arm <= sys_off;
      on_cnt <= '0;
    end else if (on_done) begin
      on_arm <= 1'b0;
    end else if (on_arm && tick_ms) begin
      on_cnt <= on_cnt + ON_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_arm <= 1'b0;
      off_cnt <= '0;
    end else if (!btn_pressed) begin
      off_arm <= 1'b0;
    end else if (press) begin
      off_arm <= 1'b1;
      off_cnt <= '0;
    end else if (off_done || sus_hit) begin
      off_arm <= 1'b0;
    end else if (off_arm && tick_ms) begin
      off_cnt <= off_cnt + OFF_W'(1);
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic btn_pressed,
  input logic lid_open,
  input logic sys_off,
  input logic s0_to_s3,
  input logic pwr_on_req,
  input logic force_off_req
);
  logic up;
  always_ff @(posedge clk) up <= rst_n;

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !up |-> (!pwr_on_req && !force_off_req));

  assert_lid_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $rose(lid_open) && sys_off) |=> pwr_on_req);

  assert_suspend_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_to_s3 && btn_pressed) |=> force_off_req);

  assert_pwr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_req |=> !pwr_on_req);

  assert_force_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_req |=> !force_off_req);

  assert_force_needs_button_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_req |-> $past(btn_pressed));

  assert_pwr_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_req |-> ($past(btn_pressed) || $past(lid_open)));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_pwr_wake_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .btn_pressed(btn_pressed), .lid_open(lid_open),
  .sys_off(sys_off), .s0_to_s3(s0_to_s3), .pwr_on_req(pwr_on_req),
  .force_off_req(force_off_req)
);

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
  localparam int ON_MS  = 10;
  localparam int OFF_MS = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, btn_pressed = 1'b0, lid_open = 1'b0;
  logic sys_off = 1'b0, s0_to_s3 = 1'b0;
  logic pwr_on_req, force_off_req;

  always #10 clk = ~clk;

  pwr_wake_ctrl #(.ON_HOLD_MS(ON_MS), .OFF_HOLD_MS(OFF_MS)) i_pwr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_pressed(btn_pressed),
    .lid_open(lid_open), .sys_off(sys_off), .s0_to_s3(s0_to_s3),
    .pwr_on_req(pwr_on_req), .force_off_req(force_off_req)
  );

  typedef struct { bit kind; int cyc; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit done = 0;

  function automatic string kname(bit k);
    return k ? "force_off_req" : "pwr_on_req";
  endfunction

  task automatic push(bit k, string r);
    exp_t e;
    e.kind = k; e.cyc = cyc + 1; e.req = r;
    q.push_back(e);
  endtask

  task automatic see(bit k);
    total++;
    if (q.size() != 0 && q[0].cyc == cyc && q[0].kind == k) begin
      void'(q.pop_front());
    end else begin
      bad++;
      $display("FAIL R9 unexpected %s at cycle %0d actual=1 expected=0", kname(k), cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    while (q.size() != 0 && q[0].cyc < cyc) begin
      total++; bad++;
      $display("FAIL %s missing %s at cycle %0d actual=0 expected=1",
               q[0].req, kname(q[0].kind), q[0].cyc);
      void'(q.pop_front());
    end
    if (pwr_on_req) see(1'b0);
    if (force_off_req) see(1'b1);
  end

  task automatic drained(string r);
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL %s pending expectations actual=%0d expected=0", r, q.size());
      q.delete();
    end
  endtask

  task automatic press();
    @(negedge clk); btn_pressed = 1'b1; tick_ms = 1'b0;
  endtask

  task automatic release_btn();
    @(negedge clk); btn_pressed = 1'b0; tick_ms = 1'b0;
  endtask

  task automatic hold(int n, int on_at, int off_at, string r_on, string r_off);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick_ms = 1'b1;
      if (i == on_at) push(1'b0, r_on);
      if (i == off_at) push(1'b1, r_off);
      @(negedge clk); tick_ms = 1'b0;
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    // R1: levels high across reset release
    btn_pressed = 1'b1; lid_open = 1'b1; sys_off = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (pwr_on_req !== 1'b0 || force_off_req !== 1'b0) begin
      bad++;
      $display("FAIL R1 outputs in reset actual=%b%b expected=00", pwr_on_req, force_off_req);
    end
    rst_n = 1'b1;
    hold(20, 0, 0, "R1", "R1");
    drained("R1");
    release_btn();
    @(negedge clk); lid_open = 1'b0;
    drained("R1");

    // R2 and R9: wake from off, no refire while still held
    press(); hold(14, ON_MS, 0, "R2", ""); release_btn(); drained("R2");

    // R3: press while running, no wake
    sys_off = 1'b0;
    press(); hold(14, 0, 0, "", ""); release_btn(); drained("R3");

    // R5: early release, then a fresh count
    sys_off = 1'b1;
    press(); hold(ON_MS - 1, 0, 0, "", ""); release_btn(); drained("R5");
    press(); hold(ON_MS, ON_MS, 0, "R5", ""); release_btn(); drained("R5");

    // R4 and R9: long hold while running
    sys_off = 1'b0;
    press(); hold(OFF_MS + 5, 0, OFF_MS, "", "R4"); release_btn(); drained("R4");

    // R4 with R2: wake, then forced off on the same hold
    sys_off = 1'b1;
    press(); hold(OFF_MS + 2, ON_MS, OFF_MS, "R2", "R4"); release_btn(); drained("R4");

    // R5: release one tick short of shutdown
    sys_off = 1'b0;
    press(); hold(OFF_MS - 1, 0, 0, "", ""); release_btn(); drained("R5");

    // R6: lid wake while off, held open, then while running
    @(negedge clk); sys_off = 1'b1; lid_open = 1'b1; push(1'b0, "R6");
    repeat (10) @(negedge clk);
    lid_open = 1'b0;
    drained("R6");
    @(negedge clk); sys_off = 1'b0; lid_open = 1'b1;
    repeat (5) @(negedge clk);
    lid_open = 1'b0;
    drained("R6");

    // R7: suspend entry while held, then timer stays cancelled
    press(); hold(100, 0, 0, "", "");
    @(negedge clk); s0_to_s3 = 1'b1; push(1'b1, "R7");
    @(negedge clk); s0_to_s3 = 1'b0;
    hold(OFF_MS, 0, 0, "", ""); release_btn(); drained("R7");

    // R8: suspend entry with button released
    @(negedge clk); s0_to_s3 = 1'b1;
    @(negedge clk); s0_to_s3 = 1'b0;
    hold(5, 0, 0, "", "");
    drained("R8");

    report();
  end
endmodule